// File: doc/BRIEF.md
# External Data-Memory Access Sequencer

This block times one data-memory access issued by a processor core. Its time base is a machine-cycle tick: a one-clock pulse at the start of every machine cycle. A request is taken on a tick while the block is idle. From then on the block counts machine cycles and drives a read strobe or a write strobe toward the external device, according to the direction the request carried.

For an external access, a 3-bit stretch value N sets the length to N+2 machine cycles, so a slow memory or peripheral gets a longer strobe without extra glue logic. The strobe stays low for the first machine cycle and then holds through the remaining N+1 cycles. An access marked internal, meaning on-chip memory, always takes two machine cycles whatever the stretch value, and it drives neither external strobe.

`busy_o` covers the whole access. `done_o` is a one-clock pulse that closes it. The stretch value, the direction and the internal/external select are all captured when the request is taken. Requests that arrive during an access are dropped. The control register that supplies the stretch value resets it to 1, which gives three-cycle external accesses.

Top module: `xacc_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_stb_o` and `wr_stb_o` are all low.
- R2: A request is taken only on a clock edge where `req_i` and `mc_tick_i` are both high and the block is idle. `busy_o` rises in the clock after that edge. A request on an edge without a tick has no effect.
- R3: An external access (`int_sel_i`=0) with stretch value N (0..7) keeps `busy_o` high for exactly N+2 machine cycles, that is (N+2) tick periods of clocks.
- R4: In an external access, the strobe selected by `wr_i` (0 = read strobe, 1 = write strobe) is low during the first machine cycle. It is high for the following N+1 machine cycles and falls together with `busy_o`. The other strobe stays low.
- R5: `done_o` is high for exactly one clock: the clock that follows the last high clock of `busy_o`, during which `busy_o` is already low.
- R6: An internal access (`int_sel_i`=1) lasts exactly 2 machine cycles for any stretch value, and neither strobe is asserted during it.
- R7: The stretch value, `wr_i` and `int_sel_i` are captured when the request is taken. Changing them during an access does not change its length or its strobe.
- R8: A request made while `busy_o` is high is ignored: it neither lengthens the current access nor starts another after it.
- R9: The end values of the stretch range hold: N=0 gives a 2-cycle access with a 1-cycle strobe, and N=7 gives a 9-cycle access with an 8-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_tick_i | input | 1 | One-clock pulse marking the start of each machine cycle |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | Direction: 0 read, 1 write |
| int_sel_i | input | 1 | 1 = on-chip memory access, 0 = external access |
| stretch_i | input | 3 | Stretch value N |
| rd_stb_o | output | 1 | External read strobe |
| wr_stb_o | output | 1 | External write strobe |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock end-of-access pulse |

## Verification
Let P be the tick period in clocks and L the access length in machine cycles. Once a request is taken at a tick edge, `busy_o` is due one clock later and stays high for L·P clocks. The strobe follows P clocks after that for (L−1)·P clocks, and `done_o` arrives in the clock after `busy_o` falls. The driver pushes these three clock counts into a queue when it issues a request. The monitor samples at falling edges, counts high clocks on each output, and compares against the queue when `done_o` appears, so the whole window is checked without fixing the absolute cycle of the request. A `done_o` with nothing queued shows that a dropped request was wrongly accepted.

// File: rtl/xacc_pkg.sv
`timescale 1ns/1ps
package xacc_pkg;

   // direction of the access as carried on wr_i
   typedef enum logic {
      XACC_RD = 1'b0,
      XACC_WR = 1'b1
   } xacc_dir_e;

   // attributes captured when a request is taken
   typedef struct packed {
      logic      ext;
      xacc_dir_e dir;
   } xacc_attr_t;

   // longest access in machine cycles for a given stretch width
   function automatic int unsigned xacc_max_len(input int unsigned stretch_w,
                                                input int unsigned base_cycles,
                                                input int unsigned int_cycles);
      int unsigned ext_max;
      ext_max = base_cycles + (32'd1 << stretch_w) - 1;
      return (ext_max > int_cycles) ? ext_max : int_cycles;
   endfunction

endpackage

// File: rtl/xacc_len_calc.sv
`timescale 1ns/1ps
module xacc_len_calc #(
   parameter int unsigned STRETCH_W   = 3,
   parameter int unsigned BASE_CYCLES = 2,
   parameter int unsigned INT_CYCLES  = 2,
   parameter int unsigned CNT_W       = 4
) (
   input  logic [STRETCH_W-1:0] stretch_i,
   input  logic                 int_sel_i,
   output logic [CNT_W-1:0]     len_o
);

   logic [CNT_W-1:0] ext_len;

   // external: base plus stretch, on-chip: fixed
   assign ext_len = CNT_W'(BASE_CYCLES) + CNT_W'(stretch_i);
   assign len_o   = int_sel_i ? CNT_W'(INT_CYCLES) : ext_len;

   initial begin
      assert (CNT_W >= 2) else $error("xacc_len_calc: CNT_W too small");
   end

endmodule

// File: rtl/xacc_cycle_ctrl.sv
`timescale 1ns/1ps
module xacc_cycle_ctrl #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             first_o
);

   logic             busy_q;
   logic             done_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic             last_mc;

   assign last_mc = (cnt_q == len_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         len_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
            len_q  <= len_i;
         end else if (busy_q && tick_i) begin
            if (last_mc) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign busy_o  = busy_q;
   assign done_o  = done_q;
   assign first_o = (cnt_q == CNT_W'(1));

   // R3
   cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> (cnt_q >= CNT_W'(1)) && (cnt_q <= len_q));

   // R7
   len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> $stable(len_q));

   // R5
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

   // R5
   busy_fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_q) |-> done_q);

endmodule

// File: rtl/xacc_strobe_dec.sv
`timescale 1ns/1ps
module xacc_strobe_dec
   import xacc_pkg::*;
#(
   parameter int unsigned N_DIR = 2
) (
   input  logic             busy_i,
   input  logic             first_i,
   input  xacc_attr_t       attr_i,
   output logic [N_DIR-1:0] stb_o
);

   // one strobe per direction, live after the first machine cycle
   for (genvar d = 0; d < N_DIR; d++) begin : g_stb
      assign stb_o[d] = busy_i && attr_i.ext && !first_i &&
                        (int'(attr_i.dir) == d);
   end

   initial begin
      assert (N_DIR == 2) else $error("xacc_strobe_dec: N_DIR must be 2");
   end

endmodule

// File: rtl/xacc_seq.sv
`timescale 1ns/1ps
module xacc_seq
   import xacc_pkg::*;
#(
   parameter int unsigned STRETCH_W   = 3,
   parameter int unsigned BASE_CYCLES = 2,
   parameter int unsigned INT_CYCLES  = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 mc_tick_i,
   input  logic                 req_i,
   input  logic                 wr_i,
   input  logic                 int_sel_i,
   input  logic [STRETCH_W-1:0] stretch_i,
   output logic                 rd_stb_o,
   output logic                 wr_stb_o,
   output logic                 busy_o,
   output logic                 done_o
);

   localparam int unsigned MAX_LEN = xacc_max_len(STRETCH_W, BASE_CYCLES, INT_CYCLES);
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

   logic             accept;
   logic [CNT_W-1:0] len_in;
   logic             first_mc;
   logic             busy;
   xacc_attr_t       attr_q;
   logic [1:0]       stb;

   initial begin
      assert (STRETCH_W >= 1 && STRETCH_W <= 8) else $error("xacc_seq: STRETCH_W out of range");
      assert (BASE_CYCLES >= 2) else $error("xacc_seq: BASE_CYCLES must leave a strobe cycle");
      assert (INT_CYCLES >= 1) else $error("xacc_seq: INT_CYCLES must be positive");
   end

   assign accept = req_i && mc_tick_i && !busy;

   xacc_len_calc #(
      .STRETCH_W   (STRETCH_W),
      .BASE_CYCLES (BASE_CYCLES),
      .INT_CYCLES  (INT_CYCLES),
      .CNT_W       (CNT_W)
   ) i_len (
      .stretch_i (stretch_i),
      .int_sel_i (int_sel_i),
      .len_o     (len_in)
   );

   xacc_cycle_ctrl #(
      .CNT_W (CNT_W)
   ) i_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (mc_tick_i),
      .start_i (accept),
      .len_i   (len_in),
      .busy_o  (busy),
      .done_o  (done_o),
      .first_o (first_mc)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         attr_q <= '{ext: 1'b0, dir: XACC_RD};
      end else if (accept) begin
         attr_q <= '{ext: !int_sel_i, dir: xacc_dir_e'(wr_i)};
      end
   end

   xacc_strobe_dec #(
      .N_DIR (2)
   ) i_dec (
      .busy_i  (busy),
      .first_i (first_mc),
      .attr_i  (attr_q),
      .stb_o   (stb)
   );

   assign rd_stb_o = stb[XACC_RD];
   assign wr_stb_o = stb[XACC_WR];
   assign busy_o   = busy;

   // R1
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !rd_stb_o && !wr_stb_o);

   // R4
   strobe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(rd_stb_o) || $rose(wr_stb_o)) |-> $past(busy_o));

   // R4
   strobe_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(rd_stb_o) || $fell(wr_stb_o)) |-> $fell(busy_o));

endmodule

// File: tb/test_xacc_seq.sv
`timescale 1ns/1ps
module test_xacc_seq;

   localparam int P = 4;

   typedef struct {
      int    busy_clk;
      int    rd_clk;
      int    wr_clk;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       req = 1'b0;
   logic       wr = 1'b0;
   logic       isel = 1'b0;
   logic [2:0] stretch = 3'd1;
   logic       rd_stb, wr_stb, busy, done;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   int   bcnt = 0, rcnt = 0, wcnt = 0;
   logic prev_done = 1'b0;
   int   tcnt = 0;

   always #2.5 clk = ~clk;

   xacc_seq i_xacc_seq (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .mc_tick_i (tick),
      .req_i     (req),
      .wr_i      (wr),
      .int_sel_i (isel),
      .stretch_i (stretch),
      .rd_stb_o  (rd_stb),
      .wr_stb_o  (wr_stb),
      .busy_o    (busy),
      .done_o    (done)
   );

   // machine-cycle tick, one clock in every P
   always @(negedge clk) begin
      tick <= (tcnt == P - 1);
      tcnt <= (tcnt == P - 1) ? 0 : tcnt + 1;
   end

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   task automatic wait_tick_slot();
      forever begin
         @(negedge clk);
         #0.5;
         if (tick) break;
      end
   endtask

   // driver: issue one access and queue its expected profile
   task automatic issue(input bit w, input bit in_mem, input int n, input string tag);
      exp_t e;
      int   len;
      len = in_mem ? 2 : n + 2;
      e.busy_clk = len * P;
      e.rd_clk   = (!in_mem && !w) ? (len - 1) * P : 0;
      e.wr_clk   = (!in_mem &&  w) ? (len - 1) * P : 0;
      e.tag      = tag;
      wait_tick_slot();
      exp_q.push_back(e);
      req = 1'b1; wr = w; isel = in_mem; stretch = 3'(n);
      @(negedge clk);
      #0.5;
      req = 1'b0;
   endtask

   task automatic drain();
      wait (exp_q.size() == 0);
      repeat (3) @(negedge clk);
   endtask

   // monitor: count high clocks, compare on done
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy)   bcnt++;
         if (rd_stb) rcnt++;
         if (wr_stb) wcnt++;
         if (done) begin
            check(!(prev_done), "R5 done width", 2, 1);
            check(!busy, "R5 busy low with done", int'(busy), 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected access completed", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(bcnt == e.busy_clk, {e.tag, " busy clocks"}, bcnt, e.busy_clk);
               check(rcnt == e.rd_clk,   {e.tag, " read strobe clocks"}, rcnt, e.rd_clk);
               check(wcnt == e.wr_clk,   {e.tag, " write strobe clocks"}, wcnt, e.wr_clk);
            end
            bcnt = 0; rcnt = 0; wcnt = 0;
         end
         prev_done = done;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1: quiet outputs in and after reset
      check({busy, done, rd_stb, wr_stb} == 4'b0, "R1 reset outputs",
            int'({busy, done, rd_stb, wr_stb}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check({busy, done, rd_stb, wr_stb} == 4'b0, "R1 idle after reset",
            int'({busy, done, rd_stb, wr_stb}), 0);

      // R2: request without a tick is not taken
      forever begin
         @(negedge clk);
         #0.5;
         if (!tick) break;
      end
      req = 1'b1;
      @(negedge clk);
      check(!busy, "R2 no tick, no start", int'(busy), 0);
      #0.5;
      req = 1'b0;
      repeat (2) @(negedge clk);

      // R3 R4: default stretch, read
      issue(1'b0, 1'b0, 1, "R3 R4 read N=1");
      drain();
      // R9: stretch ends
      issue(1'b1, 1'b0, 0, "R9 write N=0");
      drain();
      issue(1'b0, 1'b0, 7, "R9 read N=7");
      drain();
      issue(1'b1, 1'b0, 3, "R3 R4 write N=3");
      drain();

      // R6: on-chip accesses ignore stretch, no strobes
      issue(1'b0, 1'b1, 5, "R6 internal read N=5");
      drain();
      issue(1'b1, 1'b1, 7, "R6 internal write N=7");
      drain();

      // R7: change settings mid-access
      issue(1'b0, 1'b0, 2, "R7 settings captured");
      repeat (6) @(negedge clk);
      stretch = 3'd7; wr = 1'b1; isel = 1'b1;
      drain();

      // R8: request during busy ignored
      issue(1'b0, 1'b0, 3, "R8 access with dropped request");
      wait_tick_slot();
      req = 1'b1; wr = 1'b1; isel = 1'b0; stretch = 3'd0;
      @(negedge clk);
      #0.5;
      req = 1'b0;
      drain();
      repeat (40) @(negedge clk);
      check(!busy, "R8 no extra access", int'(busy), 0);
      check(exp_q.size() == 0, "R8 queue empty", exp_q.size(), 0);

      summary();
      $finish;
   end

endmodule